// File: doc/BRIEF.md
# Script Register-Operation ALU

This unit carries out the byte-wide register arithmetic of a small script processor. A 32-bit instruction word names one byte in a 128-entry register file and an operation. It also names a routing form, which decides where the source operand comes from and where the result goes. The unit keeps an accumulator byte that holds the first byte of a transfer, and a carry flag that add-with-carry and the two shifts use and update.

The routing form is taken from bits 31:27 and can be one of three. In the first, a register receives the accumulator combined with the data operand. In the second, the accumulator receives a register combined with the data operand. In the third, a register receives itself combined with the data operand. The data operand is the 8-bit immediate in bits 15:8, unless bit 23 asks for the accumulator in its place.

Instructions arrive over a valid/ready handshake. Each one finishes with a single-cycle done pulse, and an illegal flag is raised with that pulse when the routing code is not recognised. Debug read ports show any register, the accumulator and the carry at all times. Copying a register into the accumulator is done as an OR with immediate zero in the accumulator-destination form. The register-destination form copies the other way.

Top module: `scr_regop_alu`

## Requirements
- R1: While rst_n is low at a clock edge, the unit clears all 128 registers, the accumulator and the carry to 0, and drops done and illegal. After reset, instr_ready is 1.
- R2: An instruction is accepted on a rising edge where instr_valid and instr_ready are both 1. instr_ready is 0 in the cycle that follows acceptance. Done is 1 for exactly one cycle, starting at the second rising edge after acceptance, and the instruction's results are visible on the debug ports in that same cycle. When instr_valid is low, no instruction is accepted and done stays 0.
- R3: Bits 31:27 choose the routing form. 5'b01101 writes register[bits 22:16] with accumulator op data. 5'b01110 writes the accumulator with register[bits 22:16] op data. 5'b01111 writes register[bits 22:16] with register[bits 22:16] op data. The full 7-bit address range 0 to 127 can be reached.
- R4: When bit 23 is 0, the data operand is the immediate in bits 15:8. When bit 23 is 1, the current accumulator value is used as the data operand and the immediate is ignored.
- R5: Bits 26:24 select the operation. Code 0 (load) writes the data operand unchanged. Codes 2, 3 and 4 write the source OR, XOR and AND the data operand. None of these four changes the carry.
- R6: Code 6 writes the low 8 bits of source + data and sets the carry to bit 8 of that sum. Code 7 works the same way but also adds the old carry into the sum.
- R7: Code 1 (shift left) writes {source[6:0], old carry} and sets the carry to source[7]. Code 5 (shift right) writes {old carry, source[7:1]} and sets the carry to source[0]. The data operand has no effect on either shift.
- R8: An instruction whose bits 31:27 are not one of the three routing codes still completes with done, raises illegal in that same cycle, and leaves the registers, accumulator and carry unchanged.
- R9: dbg_reg_data always shows register[dbg_reg_addr]. dbg_acc and dbg_carry always show the current accumulator and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit can take an instruction |
| instr_word | input | 32 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed instruction had an unknown routing code |
| dbg_reg_addr | input | 7 | Register index for the debug read |
| dbg_reg_data | output | 8 | Contents of the indexed register |
| dbg_acc | output | 8 | Accumulator contents |
| dbg_carry | output | 1 | Carry flag |

## Verification
An instruction taken at one rising edge is latched there, and its result is committed at the next rising edge. Done, illegal, the new register or accumulator value and the new carry all appear together in the cycle after that second edge. At the first falling edge after acceptance, done must still be 0 and instr_ready must be 0. All results are then sampled at the falling edge after the commit edge, and done is checked again one cycle later to confirm that it has fallen. Inputs change only on falling edges, so the value captured at each rising edge is never in doubt.

// File: rtl/scr_regop_pkg.sv
// Package: shared field positions, codes and decoded-instruction type for the
// script register-operation ALU. Assumes a fixed 32-bit instruction layout.
package scr_regop_pkg;

    localparam int WORD_W   = 32;
    localparam int DATA_W   = 8;
    localparam int RADDR_W  = 7;

    // Field positions inside the instruction word
    localparam int ROUTE_HI = 31;
    localparam int ROUTE_LO = 27;
    localparam int OP_HI    = 26;
    localparam int OP_LO    = 24;
    localparam int USEACC_B = 23;
    localparam int ADDR_LO  = 16;
    localparam int IMM_LO   = 8;

    localparam logic [4:0] ROUTE_REG_ACC = 5'b01101;
    localparam logic [4:0] ROUTE_ACC_REG = 5'b01110;
    localparam logic [4:0] ROUTE_REG_REG = 5'b01111;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_SHL  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_AND  = 3'd4,
        OP_SHR  = 3'd5,
        OP_ADD  = 3'd6,
        OP_ADDC = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        RT_REG_GETS_ACC = 2'd0,
        RT_ACC_GETS_REG = 2'd1,
        RT_REG_GETS_REG = 2'd2,
        RT_BAD          = 2'd3
    } route_e;

    typedef struct packed {
        route_e              route;
        alu_op_e             op;
        logic                use_acc;
        logic [RADDR_W-1:0]  addr;
        logic [DATA_W-1:0]   imm;
    } dec_instr_t;

endpackage

// File: rtl/scr_regop_decode.sv
// Module: scr_regop_decode
// Splits a 32-bit register-operation word into routing form, operation,
// data-source select, register address and immediate. Purely combinational;
// assumes the word is held stable by the caller for the whole cycle.
module scr_regop_decode
    import scr_regop_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_instr_t        dec
);

    logic [4:0] route_code;

    assign route_code = word[ROUTE_HI:ROUTE_LO];

    // Map the five routing bits onto one of three forms, or mark it bad
    always_comb begin
        unique case (route_code)
            ROUTE_REG_ACC: dec.route = RT_REG_GETS_ACC;
            ROUTE_ACC_REG: dec.route = RT_ACC_GETS_REG;
            ROUTE_REG_REG: dec.route = RT_REG_GETS_REG;
            default:       dec.route = RT_BAD;
        endcase
    end

    // Pull the remaining fixed-position fields straight out of the word
    assign dec.op      = alu_op_e'(word[OP_HI:OP_LO]);
    assign dec.use_acc = word[USEACC_B];
    assign dec.addr    = word[ADDR_LO +: RADDR_W];
    assign dec.imm     = word[IMM_LO +: DATA_W];

endmodule

// File: rtl/scr_regop_calc.sv
// Module: scr_regop_calc
// Byte-wide arithmetic and logic stage: combines a source byte and a data
// byte under one of eight operations and reports the new carry and whether
// the carry is to be written. Combinational; assumes the carry input is the
// architectural carry of the current cycle.
module scr_regop_calc
    import scr_regop_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] data,
    input  logic         cin,
    output logic [W-1:0] result,
    output logic         cout,
    output logic         carry_we
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum;
    logic             add_cin;

    // Only add-with-carry feeds the old carry into the adder
    assign add_cin = (op == OP_ADDC) ? cin : 1'b0;
    assign sum     = {1'b0, src} + {1'b0, data} + {{W{1'b0}}, add_cin};

    // Select the result byte and carry effect for the requested operation
    always_comb begin
        result   = data;
        cout     = cin;
        carry_we = 1'b0;
        unique case (op)
            OP_LOAD: result = data;
            OP_OR:   result = src | data;
            OP_XOR:  result = src ^ data;
            OP_AND:  result = src & data;
            OP_SHL: begin
                result   = {src[W-2:0], cin};
                cout     = src[W-1];
                carry_we = 1'b1;
            end
            OP_SHR: begin
                result   = {cin, src[W-1:1]};
                cout     = src[0];
                carry_we = 1'b1;
            end
            OP_ADD, OP_ADDC: begin
                result   = sum[W-1:0];
                cout     = sum[W];
                carry_we = 1'b1;
            end
            default: result = data;
        endcase
    end

endmodule

// File: rtl/scr_regop_regfile.sv
// Module: scr_regop_regfile
// Byte register file with one synchronous write port and two combinational
// read ports (operand and debug). Synchronous active-low reset clears every
// entry. Assumes at most one write per cycle.
module scr_regop_regfile #(
    parameter int ADDR_W = 7,
    parameter int W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [W-1:0]      dbg_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0]     mem_q [DEPTH];
    logic [DEPTH-1:0] hit;

    // One write-select line per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_addr == ADDR_W'(g));
    end

    // Clear all entries on reset, otherwise store into the selected entry
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (hit[i]) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    // Combinational reads for the operand path and the debug port
    assign rd_data  = mem_q[rd_addr];
    assign dbg_data = mem_q[dbg_addr];

endmodule

// File: rtl/scr_regop_alu.sv
// Module: scr_regop_alu (top)
// Executes one register-arithmetic instruction per two cycles: the word is
// latched on acceptance, decoded and committed on the following edge, and
// done (with illegal for an unknown routing code) pulses in the cycle after
// the commit. Holds the accumulator, carry and register file. Synchronous
// active-low reset. Assumes instr_word is valid whenever instr_valid is high.
module scr_regop_alu
    import scr_regop_pkg::*;
#(
    parameter int ADDR_W = RADDR_W,
    parameter int W      = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [31:0]       instr_word,
    output logic              done,
    output logic              illegal,
    input  logic [ADDR_W-1:0] dbg_reg_addr,
    output logic [W-1:0]      dbg_reg_data,
    output logic [W-1:0]      dbg_acc,
    output logic              dbg_carry
);

    logic [31:0]  word_q;
    logic         busy_q;
    logic         done_q;
    logic         illegal_q;
    logic [W-1:0] acc_q;
    logic         carry_q;

    dec_instr_t   dec;
    logic         legal;
    logic         commit;
    logic [W-1:0] reg_rd;
    logic [W-1:0] src;
    logic [W-1:0] data;
    logic [W-1:0] result;
    logic         cout;
    logic         carry_we;
    logic         reg_we;
    logic         acc_we;
    logic         accept;

    assign instr_ready = !busy_q;
    assign accept      = instr_valid && instr_ready;

    // Latch an accepted word and mark the execute slot as occupied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            word_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            word_q <= instr_word;
        end else begin
            busy_q <= 1'b0;
        end
    end

    scr_regop_decode u_decode (
        .word (word_q),
        .dec  (dec)
    );

    assign legal  = (dec.route != RT_BAD);
    assign commit = busy_q && legal;

    scr_regop_regfile #(
        .ADDR_W (ADDR_W),
        .W      (W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_addr  (dec.addr[ADDR_W-1:0]),
        .wr_data  (result),
        .rd_addr  (dec.addr[ADDR_W-1:0]),
        .rd_data  (reg_rd),
        .dbg_addr (dbg_reg_addr),
        .dbg_data (dbg_reg_data)
    );

    // Source byte: accumulator for the register-gets-accumulator form
    assign src  = (dec.route == RT_REG_GETS_ACC) ? acc_q : reg_rd;
    // Data byte: immediate unless the word asks for the accumulator
    assign data = dec.use_acc ? acc_q : dec.imm[W-1:0];

    scr_regop_calc #(
        .W (W)
    ) u_calc (
        .op       (dec.op),
        .src      (src),
        .data     (data),
        .cin      (carry_q),
        .result   (result),
        .cout     (cout),
        .carry_we (carry_we)
    );

    assign acc_we = commit && (dec.route == RT_ACC_GETS_REG);
    assign reg_we = commit && (dec.route != RT_ACC_GETS_REG);

    // Accumulator and carry update on a committed instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (acc_we) begin
                acc_q <= result;
            end
            if (commit && carry_we) begin
                carry_q <= cout;
            end
        end
    end

    // Completion pulse and illegal flag, one cycle after the commit edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= busy_q;
            illegal_q <= busy_q && !legal;
        end
    end

    assign done      = done_q;
    assign illegal   = illegal_q;
    assign dbg_acc   = acc_q;
    assign dbg_carry = carry_q;

endmodule

// File: rtl/scr_regop_alu_chk.sv
// Module: scr_regop_alu_chk
// Protocol and carry-rule checker for scr_regop_alu, attached by bind. It
// keeps its own copy of the last accepted word to judge each completion.
module scr_regop_alu_chk #(
    parameter int ADDR_W = 7,
    parameter int W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              instr_ready,
    input logic [31:0]       instr_word,
    input logic              done,
    input logic              illegal,
    input logic [ADDR_W-1:0] dbg_reg_addr,
    input logic [W-1:0]      dbg_reg_data,
    input logic [W-1:0]      dbg_acc,
    input logic              dbg_carry
);

    logic [31:0] cap_q;
    logic        acc_handshake;
    logic        logic_op;
    logic        acc_load_imm;

    assign acc_handshake = instr_valid && instr_ready;

    // Remember the word of the instruction now in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (acc_handshake) begin
            cap_q <= instr_word;
        end
    end

    assign logic_op     = (cap_q[26:24] == 3'd0) || (cap_q[26:24] == 3'd2) ||
                          (cap_q[26:24] == 3'd3) || (cap_q[26:24] == 3'd4);
    assign acc_load_imm = (cap_q[31:27] == 5'b01110) && (cap_q[26:24] == 3'd0) &&
                          !cap_q[23];

    // R2: ready falls right after acceptance
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        acc_handshake |=> !instr_ready);

    // R2: done arrives at the second edge after acceptance
    a_r2_done_due: assert property (@(posedge clk) disable iff (!rst_n)
        acc_handshake |=> ##1 done);

    // R2: done lasts one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: illegal only alongside done
    a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    // R8: illegal leaves accumulator and carry alone
    a_r8_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(dbg_acc) && $stable(dbg_carry)));

    // R5: load and bitwise operations keep the carry
    a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && logic_op) |-> $stable(dbg_carry));

    // R5: accumulator load from immediate writes the immediate unchanged
    a_r5_acc_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done && acc_load_imm) |-> (dbg_acc == cap_q[15:8]));

endmodule

bind scr_regop_alu scr_regop_alu_chk #(.ADDR_W(ADDR_W), .W(W)) chk_i (.*);

// File: tb/scr_regop_alu_tb.sv
// Bench for scr_regop_alu: a vector table walked by one loop, then directed
// tests for reset, handshake, illegal codes and operand edge cases.
module scr_regop_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    localparam logic [4:0] RA = 5'b01101;  // register = acc op data
    localparam logic [4:0] AR = 5'b01110;  // acc = register op data
    localparam logic [4:0] RR = 5'b01111;  // register = register op data

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [31:0] instr_word = '0;
    logic        done;
    logic        illegal;
    logic [6:0]  dbg_reg_addr = '0;
    logic [7:0]  dbg_reg_data;
    logic [7:0]  dbg_acc;
    logic        dbg_carry;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;
    logic mid_done;
    logic mid_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    scr_regop_alu dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_ready  (instr_ready),
        .instr_word   (instr_word),
        .done         (done),
        .illegal      (illegal),
        .dbg_reg_addr (dbg_reg_addr),
        .dbg_reg_data (dbg_reg_data),
        .dbg_acc      (dbg_acc),
        .dbg_carry    (dbg_carry)
    );

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [2:0] op,
                                       input logic ua, input logic [6:0] a,
                                       input logic [7:0] imm);
        return {rt, op, ua, a, imm, 8'h00};
    endfunction

    // Vector table: word, expected target value, expected carry
    localparam logic [31:0] VW [NVEC] = '{
        {AR, 3'd0, 1'b0, 7'd0,   8'hA5, 8'h00},  // acc = A5
        {RA, 3'd2, 1'b0, 7'd3,   8'h00, 8'h00},  // r3 = acc | 0
        {RR, 3'd3, 1'b0, 7'd3,   8'hFF, 8'h00},  // r3 ^= FF
        {RR, 3'd4, 1'b0, 7'd3,   8'h0F, 8'h00},  // r3 &= 0F
        {RR, 3'd6, 1'b0, 7'd3,   8'hF8, 8'h00},  // r3 += F8
        {RR, 3'd7, 1'b0, 7'd3,   8'h10, 8'h00},  // r3 += 10 + c
        {RR, 3'd1, 1'b0, 7'd3,   8'hFF, 8'h00},  // r3 shl
        {RA, 3'd1, 1'b0, 7'd5,   8'h00, 8'h00},  // r5 = acc shl
        {RA, 3'd5, 1'b0, 7'd6,   8'h00, 8'h00},  // r6 = acc shr
        {RR, 3'd7, 1'b1, 7'd5,   8'hFF, 8'h00},  // r5 += acc + c
        {AR, 3'd6, 1'b1, 7'd6,   8'h00, 8'h00},  // acc = r6 + acc
        {AR, 3'd2, 1'b0, 7'd5,   8'h00, 8'h00},  // acc = r5
        {RA, 3'd0, 1'b1, 7'd7,   8'h33, 8'h00},  // r7 = acc
        {RR, 3'd5, 1'b0, 7'd7,   8'h00, 8'h00},  // r7 shr
        {RA, 3'd0, 1'b0, 7'd127, 8'h5C, 8'h00}   // r127 = 5C
    };
    localparam logic [7:0] VR [NVEC] = '{
        8'hA5, 8'hA5, 8'h5A, 8'h0A, 8'h02, 8'h13, 8'h26, 8'h4A,
        8'hD2, 8'hF0, 8'h77, 8'hF0, 8'hF0, 8'hF8, 8'h5C
    };
    localparam logic VC [NVEC] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
        1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0
    };

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one word; return at the falling edge of the done cycle
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        mid_done    = done;
        mid_ready   = instr_ready;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [6:0] a);
        dbg_reg_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(instr_ready == 1'b1, "R1 ready after reset", 32'(instr_ready), 1);
        check(done == 1'b0, "R1 done after reset", 32'(done), 0);
        check(dbg_acc == 8'h00, "R1 acc after reset", 32'(dbg_acc), 0);
        check(dbg_carry == 1'b0, "R1 carry after reset", 32'(dbg_carry), 0);
        peek(7'd127);
        check(dbg_reg_data == 8'h00, "R1 r127 after reset", 32'(dbg_reg_data), 0);

        // Table walk covering R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            issue(VW[i]);
            check(mid_done == 1'b0 && mid_ready == 1'b0, "R2 mid-cycle state",
                  32'({mid_done, mid_ready}), 0);
            check(done == 1'b1 && illegal == 1'b0, "R2 done pulse",
                  32'({done, illegal}), 32'h2);
            if (VW[i][31:27] == AR) begin
                check(dbg_acc == VR[i], $sformatf("R3 R9 vector %0d acc", i),
                      32'(dbg_acc), 32'(VR[i]));
            end else begin
                peek(VW[i][22:16]);
                check(dbg_reg_data == VR[i], $sformatf("R3 R9 vector %0d reg", i),
                      32'(dbg_reg_data), 32'(VR[i]));
            end
            check(dbg_carry == VC[i], $sformatf("R6 R7 vector %0d carry", i),
                  32'(dbg_carry), 32'(VC[i]));
            @(negedge clk);
            check(done == 1'b0, "R2 done falls", 32'(done), 0);
        end

        // R2: no acceptance while valid is low
        repeat (4) @(negedge clk);
        check(done == 1'b0 && instr_ready == 1'b1, "R2 idle", 32'({done, instr_ready}), 1);

        // R8: unknown routing codes change nothing (acc=F0, carry=0, r3=26)
        issue(mk(5'b10000, 3'd0, 1'b0, 7'd3, 8'hFF));
        check(done == 1'b1 && illegal == 1'b1, "R8 illegal pulse", 32'({done, illegal}), 3);
        peek(7'd3);
        check(dbg_reg_data == 8'h26, "R8 r3 kept", 32'(dbg_reg_data), 32'h26);
        check(dbg_acc == 8'hF0, "R8 acc kept", 32'(dbg_acc), 32'hF0);
        issue(mk(5'b01100, 3'd6, 1'b0, 7'd3, 8'hFF));
        check(illegal == 1'b1, "R8 code 01100 illegal", 32'(illegal), 1);
        check(dbg_carry == 1'b0, "R8 carry kept", 32'(dbg_carry), 0);
        peek(7'd3);
        check(dbg_reg_data == 8'h26, "R8 r3 kept again", 32'(dbg_reg_data), 32'h26);

        // R7: shift ignores immediate; r3=26 shl with c=0 -> 4C, c=0
        issue(mk(RR, 3'd1, 1'b0, 7'd3, 8'hFF));
        peek(7'd3);
        check(dbg_reg_data == 8'h4C, "R7 shl ignores data", 32'(dbg_reg_data), 32'h4C);

        // R4: bit 23 overrides immediate; acc = r127(5C) OR acc(F0) = FC
        issue(mk(AR, 3'd2, 1'b1, 7'd127, 8'h01));
        check(dbg_acc == 8'hFC, "R4 acc as data", 32'(dbg_acc), 32'hFC);

        // R6: add wrap exactly to zero; r127 = 5C + A4 = 100
        issue(mk(RR, 3'd6, 1'b0, 7'd127, 8'hA4));
        peek(7'd127);
        check(dbg_reg_data == 8'h00 && dbg_carry == 1'b1, "R6 wrap to zero",
              32'({dbg_carry, dbg_reg_data}), 32'h100);

        // R5: XOR in register-gets-acc form leaves carry 1
        issue(mk(RA, 3'd3, 1'b0, 7'd0, 8'h0F));
        peek(7'd0);
        check(dbg_reg_data == 8'hF3 && dbg_carry == 1'b1, "R5 xor keeps carry",
              32'({dbg_carry, dbg_reg_data}), 32'h1F3);

        // R1: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek(7'd0);
        check(dbg_reg_data == 8'h00 && dbg_acc == 8'h00 && dbg_carry == 1'b0,
              "R1 reset clears", 32'({dbg_carry, dbg_acc, dbg_reg_data}), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule